// File: doc/BRIEF.md
# Interrupt Request Latch, Mask and Pending Controller

This block stands between a set of external request lines and a processor core. Each request line is sampled on the core clock into a latch bit. That bit stays set after the line drops, so a request that is high for only one cycle is still seen. Software can set latch bits through a small register write port, and the core then treats them exactly as it treats hardware requests. Software can also clear latch bits through the same port.

A mask register selects which latched sources reach the core. A fixed set of sources skips the mask and always gets through. The block outputs the resulting pending vector, a valid flag and the index of the pending source with the highest priority. A lower index means a higher priority. When the core has serviced a source, it returns an acknowledge with that source's index, and the acknowledge clears the matching latch bit.

Top module: `irq_latch_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. While reset is applied and after it is released, the latch and the mask are all zero, `pend_o` is zero, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R2: When `req_i[n]` is 1 at a rising clock edge, latch bit n is 1 after that edge. It stays 1 after `req_i[n]` returns to 0, until a clear write or an acknowledge removes it.
- R3: `pend_o[n]` is 1 only when latch bit n is 1 and either mask bit n is 1 or n is a non-maskable source. A masked source never appears in `pend_o`, `irq_valid_o` or `irq_idx_o`.
- R4: Sources 0 and 1 are non-maskable. A latched bit 0 or bit 1 is pending even when the matching mask bit is 0.
- R5: Several latch bits can be set at once. Each one stays set until its own acknowledge or clear, and servicing one source leaves the others unchanged.
- R6: A write with `wr_op_i`=2'b01 (raise) ORs `wr_data_i` into the latch at the next edge.
- R7: A write with `wr_op_i`=2'b10 (clear) removes every latch bit that is set in `wr_data_i` at the next edge, unless a request or raise for that bit arrives in the same cycle.
- R8: `ack_i`=1 together with `ack_idx_i`=k clears latch bit k at the next edge. If `req_i[k]` or a raise of bit k arrives in the same cycle, bit k stays set, because the set wins.
- R9: `irq_valid_o` is 1 exactly when `pend_o` is not zero. `irq_idx_o` is then the lowest set index in `pend_o`, and it is 0 when nothing is pending.
- R10: A write with `wr_op_i`=2'b00 loads `wr_data_i` into the mask at the next edge. `wr_op_i`=2'b11 changes neither the latch nor the mask. When `wr_en_i`=0, the write port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | External request lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | Write operation: 00 mask, 01 raise, 10 clear, 11 none |
| wr_data_i | input | 16 | Write data, one bit per source |
| ack_i | input | 1 | Service acknowledge from the core |
| ack_idx_i | input | 4 | Index of the source being acknowledged |
| pend_o | output | 16 | Latched sources that are enabled by the mask or are non-maskable |
| irq_valid_o | output | 1 | At least one source is pending |
| irq_idx_o | output | 4 | Lowest pending index (highest priority) |
| latch_o | output | 16 | Current latch contents |
| mask_o | output | 16 | Current mask contents |

## Verification
The bench first applies directed patterns, each aimed at one point:
- A single one-cycle pulse on a masked source shows that capture works and that the mask blocks reporting.
- A pulse on a non-maskable source separates the mask bypass from ordinary gating.
- Three latched sources serviced one at a time show that the remaining sources stay pending and that the priority index moves on.
- An acknowledge that collides with a new request on the same bit, a reserved operation and a write with the strobe low isolate the set-wins rule and the cases that must have no effect.

After the directed part, a seeded random run mixes sparse pulses, all three write operations and acknowledges, and compares every output against a bench-side model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned DEF_NUM_SRC = 16;
  localparam logic [DEF_NUM_SRC-1:0] DEF_NMI_BITS = 16'h0003;

  typedef enum logic [1:0] {
    OP_MASK  = 2'b00,
    OP_RAISE = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } wr_op_e;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
  input  logic               wr_en_i,
  input  logic [1:0]         wr_op_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic               mask_we_o,
  output logic [NUM_SRC-1:0] raise_bits_o,
  output logic [NUM_SRC-1:0] clear_bits_o
);

  function automatic logic op_is(input logic en, input logic [1:0] op, input wr_op_e want);
    return en && (op == want);
  endfunction

  always_comb begin
    mask_we_o    = op_is(wr_en_i, wr_op_i, OP_MASK);
    raise_bits_o = op_is(wr_en_i, wr_op_i, OP_RAISE) ? wr_data_i : '0;
    clear_bits_o = op_is(wr_en_i, wr_op_i, OP_CLEAR) ? wr_data_i : '0;
  end

endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] raise_bits_i,
  input  logic [NUM_SRC-1:0] clear_bits_i,
  input  logic [NUM_SRC-1:0] ack_bits_i,
  output logic [NUM_SRC-1:0] latch_o
);

  // Set terms are ORed in after the removal terms, so a set always wins.
  function automatic logic [NUM_SRC-1:0] next_latch(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] set_hw,
    input logic [NUM_SRC-1:0] set_sw,
    input logic [NUM_SRC-1:0] rm_sw,
    input logic [NUM_SRC-1:0] rm_ack
  );
    return (cur & ~(rm_sw | rm_ack)) | set_hw | set_sw;
  endfunction

  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-1:0] latch_d;

  always_comb latch_d = next_latch(latch_q, req_i, raise_bits_i, clear_bits_i, ack_bits_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= data_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [NUM_SRC-1:0] first_hot;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_first
    if (g == 0) begin : g_top
      assign first_hot[g] = pend_i[g];
    end else begin : g_rest
      assign first_hot[g] = pend_i[g] & ~(|pend_i[g-1:0]);
    end
  end

  function automatic logic [IDX_W-1:0] encode_hot(input logic [NUM_SRC-1:0] hot);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hot[i]) acc = acc | IDX_W'(i);
    end
    return acc;
  endfunction

  assign valid_o = |pend_i;
  assign idx_o   = encode_hot(first_hot);

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  parameter logic [NUM_SRC-1:0] NMI_BITS = DEF_NMI_BITS,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_op_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_valid_o,
  output logic [IDX_W-1:0]   irq_idx_o,
  output logic [NUM_SRC-1:0] latch_o,
  output logic [NUM_SRC-1:0] mask_o
);

  function automatic logic [NUM_SRC-1:0] idx_to_bits(input logic en, input logic [IDX_W-1:0] idx);
    return en ? (NUM_SRC'(1) << idx) : '0;
  endfunction

  function automatic logic [NUM_SRC-1:0] gate_pending(
    input logic [NUM_SRC-1:0] lat,
    input logic [NUM_SRC-1:0] msk
  );
    return lat & (msk | NMI_BITS);
  endfunction

  // Named internal events, visible to the bound checker.
  logic               mask_we;
  logic [NUM_SRC-1:0] raise_bits;
  logic [NUM_SRC-1:0] clear_bits;
  logic [NUM_SRC-1:0] ack_bits;
  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;

  irq_wr_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .wr_en_i      (wr_en_i),
    .wr_op_i      (wr_op_i),
    .wr_data_i    (wr_data_i),
    .mask_we_o    (mask_we),
    .raise_bits_o (raise_bits),
    .clear_bits_o (clear_bits)
  );

  assign ack_bits = idx_to_bits(ack_i, ack_idx_i);

  irq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .raise_bits_i (raise_bits),
    .clear_bits_i (clear_bits),
    .ack_bits_i   (ack_bits),
    .latch_o      (latch_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (mask_we),
    .data_i (wr_data_i),
    .mask_o (mask_q)
  );

  assign pend = gate_pending(latch_q, mask_q);

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend_i  (pend),
    .valid_o (irq_valid_o),
    .idx_o   (irq_idx_o)
  );

  assign pend_o  = pend;
  assign latch_o = latch_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter logic [NUM_SRC-1:0] NMI_BITS = 16'h0003,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_op_i,
  input logic [NUM_SRC-1:0] wr_data_i,
  input logic               ack_i,
  input logic [IDX_W-1:0]   ack_idx_i,
  input logic [NUM_SRC-1:0] pend_o,
  input logic               irq_valid_o,
  input logic [IDX_W-1:0]   irq_idx_o,
  input logic [NUM_SRC-1:0] latch_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic [NUM_SRC-1:0] raise_bits,
  input logic [NUM_SRC-1:0] clear_bits
);

  always_comb begin
    if (!rst_n) begin
      p_reset_state_r1: assert (latch_o == '0 && mask_o == '0 && !irq_valid_o);
    end
  end

  p_capture_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_o & $past(req_i)) == $past(req_i)));

  p_pend_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~(latch_o & (mask_o | NMI_BITS))) == '0);

  p_nmi_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & NMI_BITS) == (latch_o & NMI_BITS));

  p_raise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_o & $past(raise_bits)) == $past(raise_bits)));

  p_clear_removes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_o & $past(clear_bits & ~req_i & ~raise_bits)) == '0));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_i[ack_idx_i] && !raise_bits[ack_idx_i]) |=> !latch_o[$past(ack_idx_i)]);

  p_prio_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (pend_o[irq_idx_o] &&
                     ((pend_o & ((NUM_SRC'(1) << irq_idx_o) - NUM_SRC'(1))) == '0)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (pend_o == '0 && irq_idx_o == '0));

  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_op_i == 2'b00) |=> (mask_o == $past(wr_data_i)));

  p_noop_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en_i || wr_op_i == 2'b11) && !ack_i && req_i == '0) |=> ($stable(latch_o) && $stable(mask_o)));

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NUM_SRC(NUM_SRC), .NMI_BITS(NMI_BITS)) u_chk (.*);

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = 2'b11;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic [15:0] pend;
  logic        valid;
  logic [3:0]  idx;
  logic [15:0] lat;
  logic [15:0] msk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] m_lat = '0;
  logic [15:0] m_msk = '0;

  always #2.5 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_op_i(wr_op),
    .wr_data_i(wr_data), .ack_i(ack), .ack_idx_i(ack_idx), .pend_o(pend),
    .irq_valid_o(valid), .irq_idx_o(idx), .latch_o(lat), .mask_o(msk)
  );

  function automatic logic [15:0] exp_pend(input logic [15:0] l, input logic [15:0] m);
    return l & (m | 16'h0003);
  endfunction

  function automatic logic [3:0] exp_idx(input logic [15:0] p);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 15; i >= 0; i--) if (p[i]) r = 4'(i);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [15:0] p;
    p = exp_pend(m_lat, m_msk);
    chk("R2 latch", 32'(lat), 32'(m_lat));
    chk("R10 mask", 32'(msk), 32'(m_msk));
    chk("R3 pend", 32'(pend), 32'(p));
    chk("R9 valid", 32'(valid), 32'(|p));
    chk("R9 idx", 32'(idx), 32'(exp_idx(p)));
  endtask

  task automatic idle();
    req = '0; wr_en = 1'b0; wr_op = 2'b11; wr_data = '0; ack = 1'b0; ack_idx = '0;
  endtask

  task automatic tick();
    logic [15:0] rs, cl, ab;
    @(posedge clk);
    rs = '0; cl = '0; ab = '0;
    if (wr_en) begin
      case (wr_op)
        2'b00: m_msk = wr_data;
        2'b01: rs = wr_data;
        2'b10: cl = wr_data;
        default: ;
      endcase
    end
    if (ack) ab[ack_idx] = 1'b1;
    m_lat = (m_lat & ~cl & ~ab) | req | rs;
    @(negedge clk);
    idle();
    check_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 latch in reset", 32'(lat), 32'h0);
    chk("R1 valid in reset", 32'(valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    chk("R1 idx after reset", 32'(idx), 32'h0);

    // R2 + R3: one-cycle pulse on masked source 5
    req = 16'h0020; tick();
    tick();
    chk("R2 bit held after pulse", 32'(lat[5]), 32'h1);
    chk("R3 masked source hidden", 32'(pend), 32'h0);

    // R10/R3: enable source 5
    wr_en = 1; wr_op = 2'b00; wr_data = 16'h0020; tick();
    chk("R9 idx five", 32'(idx), 32'd5);

    // R4: non-maskable source 1 with mask bit clear
    req = 16'h0002; tick();
    chk("R4 nmi pending", 32'(pend), 32'h0022);
    chk("R9 idx one", 32'(idx), 32'd1);

    // R6: raise bit 8
    wr_en = 1; wr_op = 2'b01; wr_data = 16'h0100; tick();
    chk("R6 raise sets latch", 32'(lat), 32'h0122);

    // R5/R8: ack source 1, others stay
    ack = 1; ack_idx = 4'd1; tick();
    chk("R5 others remain", 32'(lat), 32'h0120);
    chk("R8 idx moves on", 32'(idx), 32'd5);

    // R7: clear bit 5
    wr_en = 1; wr_op = 2'b10; wr_data = 16'h0020; tick();
    chk("R7 clear removes bit", 32'(lat), 32'h0100);

    // R8: set wins over ack on same bit
    ack = 1; ack_idx = 4'd8; req = 16'h0100; tick();
    chk("R8 set wins", 32'(lat[8]), 32'h1);

    // R10: reserved op and strobe low
    wr_en = 1; wr_op = 2'b11; wr_data = 16'hFFFF; tick();
    chk("R10 reserved op latch", 32'(lat), 32'h0100);
    chk("R10 reserved op mask", 32'(msk), 32'h0020);
    wr_en = 0; wr_op = 2'b01; wr_data = 16'hFFFF; tick();
    chk("R10 strobe low", 32'(lat), 32'h0100);

    // R4: raise bit 0 with mask clear
    wr_en = 1; wr_op = 2'b00; wr_data = 16'h0000; tick();
    wr_en = 1; wr_op = 2'b01; wr_data = 16'h0001; tick();
    chk("R4 bit0 pending", 32'(pend), 32'h0001);
    chk("R9 idx zero", 32'(idx), 32'd0);

    // Random phase
    void'($urandom(32'h1A2B3C4D));
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 6 == 0) req = 16'(1) << ($urandom % 16);
      if ($urandom % 4 == 0) begin
        wr_en = 1; wr_op = 2'($urandom % 4);
        wr_data = ($urandom % 2) ? 16'($urandom) : (16'(1) << ($urandom % 16));
      end
      if ($urandom % 3 == 0) begin
        ack = 1;
        ack_idx = ($urandom % 2) ? exp_idx(exp_pend(m_lat, m_msk)) : 4'($urandom % 16);
      end
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule